// File: doc/BRIEF.md
# Multicycle Stored-Program Sequencer

This block is a compact 16-bit processor core that executes a program held in the same word-addressed memory as its data. It reaches that memory only through an address register, whose value is presented on `mem_addr`, and a data register that captures `mem_rdata`. A phase sequencer fetches each instruction and then passes through decode, address evaluation, operand fetch, execute and store result, skipping every phase the instruction does not need. As a result the three supported instructions (register add, base-plus-offset load and register-indirect jump) each take a different number of cycles.

The memory array sits outside the block. It must return the word at `mem_addr` combinationally on `mem_rdata`, so a read completes one cycle after the address register is loaded. The core issues no writes. A `run` input acts as a synchronous freeze: while it is low, nothing inside the core changes. Debug outputs expose the program counter, the instruction register and the phase code, so a bench can measure how long each instruction takes.

Top module: `seq_core`

## Requirements
- R1: While `rst_n` is low, and after it, until the first advancing edge: `dbg_state` = 0, `dbg_pc` = 0x0000, `dbg_ir` = 0x0000, `mem_addr` = 0x0000, and all eight general registers are zero.
- R2: Phase codes on `dbg_state` are: 0 fetch-address, 1 fetch-wait, 2 load-IR, 3 decode, 4 evaluate-address, 5 fetch-operand, 6 execute, 7 store. A fetch takes three cycles. Phase 0 copies the PC to `mem_addr` and increments the PC. Phase 1 captures `mem_rdata`. Phase 2 moves that word into `dbg_ir`. Phase 3 follows.
- R3: Opcode 0001 (bits 15:12) is ADD. It writes reg[bits 8:6] + reg[bits 2:0], wrapped modulo 2^16, into reg[bits 11:9]. Its phases are 0,1,2,3,6,7: six cycles.
- R4: Opcode 0110 is LOAD. It puts reg[bits 8:6] plus the sign-extended 6-bit offset in bits 5:0 on `mem_addr`, then writes the word read there into reg[bits 11:9]. Its phases are 0,1,2,3,4,5,7: seven cycles.
- R5: Opcode 1100 is JUMP. It loads the PC with reg[bits 8:6]. Its phases are 0,1,2,3,7: five cycles.
- R6: Any other opcode is a no-op with phases 0,1,2,3: four cycles. It changes no register, and the PC only advances by the fetch increment.
- R7: In any cycle where `run` is low at the clock edge, `dbg_state`, `dbg_pc`, `dbg_ir`, `mem_addr` and the general registers keep their values.
- R8: `mem_addr` changes only on edges that leave phase 0 or phase 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High lets the sequencer advance; low freezes it |
| mem_addr | output | 16 | Memory address register contents |
| mem_rdata | input | 16 | Word read from memory at `mem_addr` |
| dbg_pc | output | 16 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_state | output | 3 | Current phase code |

## Verification
On every cycle, the assertions check the local rules of the phase sequencer. These rules are: the fetch increment and address copy, the branch taken out of decode for each opcode class, the freeze while `run` is low, and the address register staying put outside its two loading phases. Two kinds of result can only be shown by the bench's program run against its cycle-level reference model, compared on each clock. The first is that an instruction computes the right value: sums that wrap, negative load offsets, a load whose address is an instruction word, and jump targets. The second is that whole instructions take exactly 6, 7, 5 or 4 cycles.

// File: rtl/seq_pkg.sv
// Shared constants and the phase encoding of the multicycle sequencer.
// Assumes a fixed 16-bit instruction word with the opcode in bits 15:12.
package seq_pkg;
    localparam int OPC_W = 4;
    localparam int OFF_W = 6;

    typedef enum logic [2:0] {
        PH_FADDR = 3'd0,
        PH_FWAIT = 3'd1,
        PH_FIR   = 3'd2,
        PH_DEC   = 3'd3,
        PH_EVAL  = 3'd4,
        PH_OPER  = 3'd5,
        PH_EXEC  = 3'd6,
        PH_STORE = 3'd7
    } phase_t;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;
endpackage

// File: rtl/seq_regfile.sv
// General register file: two combinational read ports and one write port.
// Assumes writes are qualified by the caller; reset clears every entry.
module seq_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_val,
    input  logic [AW-1:0]    rd_idx_a,
    output logic [WIDTH-1:0] rd_val_a,
    input  logic [AW-1:0]    rd_idx_b,
    output logic [WIDTH-1:0] rd_val_b
);
    logic [WIDTH-1:0] regs [DEPTH];

    // One storage process per entry, so each register has its own enable.
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == AW'(g)))
                regs[g] <= wr_val;
        end
    end

    // Read ports are plain index selects.
    assign rd_val_a = regs[rd_idx_a];
    assign rd_val_b = regs[rd_idx_b];
endmodule

// File: rtl/seq_adder.sv
// Shared adder used both for register add and for effective-address add.
// Assumes the caller selects the second operand; the result wraps.
module seq_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum
);
    // Modulo-2^WIDTH addition.
    assign sum = op_a + op_b;
endmodule

// File: rtl/seq_ctrl.sv
// Phase sequencer: walks the fetch phases, then branches by opcode and
// skips unused phases. Assumes the opcode input is stable from decode on.
module seq_ctrl #(
    parameter int OPW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [OPW-1:0]  opcode,
    output seq_pkg::phase_t phase
);
    import seq_pkg::*;

    phase_t nxt;

    // Next-phase selection; each instruction class takes its own path.
    always_comb begin
        nxt = phase;
        case (phase)
            PH_FADDR: nxt = PH_FWAIT;
            PH_FWAIT: nxt = PH_FIR;
            PH_FIR:   nxt = PH_DEC;
            PH_DEC: begin
                case (opcode)
                    OPC_ADD: nxt = PH_EXEC;
                    OPC_LDR: nxt = PH_EVAL;
                    OPC_JMP: nxt = PH_STORE;
                    default: nxt = PH_FADDR;
                endcase
            end
            PH_EVAL:  nxt = PH_OPER;
            PH_OPER:  nxt = PH_STORE;
            PH_EXEC:  nxt = PH_STORE;
            PH_STORE: nxt = PH_FADDR;
            default:  nxt = PH_FADDR;
        endcase
    end

    // Phase register; held while run is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_FADDR;
        else if (run)
            phase <= nxt;
    end
endmodule

// File: rtl/seq_core.sv
// Multicycle core top: PC, IR, memory address/data registers and a result
// latch, around the register file, shared adder and phase sequencer.
// Assumes mem_rdata returns the word at mem_addr within the same cycle.
module seq_core #(
    parameter int XLEN  = 16,
    parameter int NREGS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] dbg_pc,
    output logic [XLEN-1:0] dbg_ir,
    output logic [2:0]      dbg_state
);
    import seq_pkg::*;

    localparam int RW = $clog2(NREGS);

    logic [XLEN-1:0] pc_q, ir_q, mar_q, mdr_q, res_q;
    logic [XLEN-1:0] rf_a, rf_b, add_b, add_out, off_ext;
    logic            is_add, is_ldr, is_jmp, rf_we;
    phase_t          phase;

    // Instruction field decode.
    assign is_add  = ir_q[15:12] == OPC_ADD;
    assign is_ldr  = ir_q[15:12] == OPC_LDR;
    assign is_jmp  = ir_q[15:12] == OPC_JMP;
    assign off_ext = {{(XLEN-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

    // Second adder operand: offset while evaluating address, else register.
    assign add_b = (phase == PH_EVAL) ? off_ext : rf_b;

    // Register write strobe, raised only in the store phase.
    assign rf_we = run && (phase == PH_STORE) && (is_add || is_ldr);

    seq_ctrl #(.OPW(OPC_W)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .opcode (ir_q[15:12]),
        .phase  (phase)
    );

    seq_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) i_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_idx   (ir_q[11:9]),
        .wr_val   (is_ldr ? mdr_q : res_q),
        .rd_idx_a (ir_q[8:6]),
        .rd_val_a (rf_a),
        .rd_idx_b (ir_q[2:0]),
        .rd_val_b (rf_b)
    );

    seq_adder #(.WIDTH(XLEN)) i_add (
        .op_a (rf_a),
        .op_b (add_b),
        .sum  (add_out)
    );

    // Datapath registers, each loaded only in the phase that owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            res_q <= '0;
        end else if (run) begin
            case (phase)
                PH_FADDR: begin
                    mar_q <= pc_q;
                    pc_q  <= pc_q + XLEN'(1);
                end
                PH_FWAIT: mdr_q <= mem_rdata;
                PH_FIR:   ir_q  <= mdr_q;
                PH_EVAL:  mar_q <= add_out;
                PH_OPER:  mdr_q <= mem_rdata;
                PH_EXEC:  res_q <= add_out;
                PH_STORE: if (is_jmp) pc_q <= rf_a;
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign dbg_pc    = pc_q;
    assign dbg_ir    = ir_q;
    assign dbg_state = phase;
endmodule

// File: rtl/seq_core_chk.sv
// Protocol checker for seq_core, bound to every instance of the top.
// Assumes the phase codes listed in the brief.
module seq_core_chk #(
    parameter int XLEN = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] dbg_pc,
    input logic [XLEN-1:0] dbg_ir,
    input logic [2:0]      dbg_state
);
    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state == 3'd0) |=> (dbg_state == 3'd1 &&
        mem_addr == $past(dbg_pc) && dbg_pc == $past(dbg_pc) + XLEN'(1)));

    // R2
    fetch_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state == 3'd2) |=> (dbg_state == 3'd3));

    // R3
    add_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state == 3'd3 && dbg_ir[15:12] == 4'b0001) |=> (dbg_state == 3'd6));

    // R4
    load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state == 3'd3 && dbg_ir[15:12] == 4'b0110) |=> (dbg_state == 3'd4));

    // R5
    jump_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state == 3'd3 && dbg_ir[15:12] == 4'b1100) |=> (dbg_state == 3'd7));

    // R6
    nop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state == 3'd3 && dbg_ir[15:12] != 4'b0001 &&
         dbg_ir[15:12] != 4'b0110 && dbg_ir[15:12] != 4'b1100)
        |=> (dbg_state == 3'd0 && $stable(dbg_pc)));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(dbg_state) && $stable(dbg_pc) &&
                  $stable(dbg_ir) && $stable(mem_addr)));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbg_state != 3'd0 && dbg_state != 3'd4) |=> $stable(mem_addr));
endmodule

bind seq_core seq_core_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_seq_core.sv
// Bench for seq_core: program in a local memory, behavioural cycle model,
// comparison on every falling edge, per-instruction cycle counts.
module test_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b1;
    logic [15:0] mem_addr, mem_rdata, dbg_pc, dbg_ir;
    logic [2:0]  dbg_state;

    logic [15:0] mem [256];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    seq_core i_seq_core (
        .clk(clk), .rst_n(rst_n), .run(run), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_state(dbg_state)
    );

    function automatic logic [15:0] e_add(int d, int a, int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] e_ldr(int d, int b, int off);
        return {4'b0110, 3'(d), 3'(b), 6'(off)};
    endfunction
    function automatic logic [15:0] e_jmp(int b);
        return {4'b1100, 3'b000, 3'(b), 6'b000000};
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    // Behavioural reference: instruction-level meaning spread over cycles.
    int          m_ph = 0;
    logic [15:0] m_pc = 0, m_ir = 0, m_mar = 0, m_mdr = 0, m_res = 0;
    logic [15:0] m_r [8];
    bit          run_edge = 1;

    always @(posedge clk) begin
        run_edge = run;
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_ir = 0; m_mar = 0; m_mdr = 0; m_res = 0;
            foreach (m_r[k]) m_r[k] = 0;
        end else if (run) begin
            case (m_ph)
                0: begin m_mar = m_pc; m_pc = m_pc + 1; m_ph = 1; end
                1: begin m_mdr = mem[m_mar[7:0]]; m_ph = 2; end
                2: begin m_ir = m_mdr; m_ph = 3; end
                3: case (m_ir[15:12])
                       4'b0001: m_ph = 6;
                       4'b0110: m_ph = 4;
                       4'b1100: m_ph = 7;
                       default: m_ph = 0;
                   endcase
                4: begin m_mar = m_r[m_ir[8:6]] + {{10{m_ir[5]}}, m_ir[5:0]}; m_ph = 5; end
                5: begin m_mdr = mem[m_mar[7:0]]; m_ph = 7; end
                6: begin m_res = m_r[m_ir[8:6]] + m_r[m_ir[2:0]]; m_ph = 7; end
                default: begin
                    if (m_ir[15:12] == 4'b0001) m_r[m_ir[11:9]] = m_res;
                    else if (m_ir[15:12] == 4'b0110) m_r[m_ir[11:9]] = m_mdr;
                    else m_pc = m_r[m_ir[8:6]];
                    m_ph = 0;
                end
            endcase
        end
    end

    // Every-cycle comparison, freeze check and instruction length check.
    logic [15:0] p_pc = 0, p_ir = 0, p_addr = 0;
    logic [2:0]  p_st = 0;
    int          len = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(dbg_state == 3'(m_ph), "R2 phase", 16'(dbg_state), 16'(m_ph));
            check(dbg_pc == m_pc, "R2 pc", dbg_pc, m_pc);
            check(dbg_ir == m_ir, "R2 ir", dbg_ir, m_ir);
            check(mem_addr == m_mar, "R8 addr", mem_addr, m_mar);
            if (!run_edge) begin
                check(dbg_state == p_st && dbg_pc == p_pc && dbg_ir == p_ir &&
                      mem_addr == p_addr, "R7 freeze", dbg_pc, p_pc);
            end
            if (dbg_state != p_st) begin
                len++;
                if (dbg_state == 3'd0) begin
                    case (dbg_ir[15:12])
                        4'b0001: check(len == 6, "R3 add cycles", 16'(len), 16'd6);
                        4'b0110: check(len == 7, "R4 load cycles", 16'(len), 16'd7);
                        4'b1100: check(len == 5, "R5 jump cycles", 16'(len), 16'd5);
                        default: check(len == 4, "R6 nop cycles", 16'(len), 16'd4);
                    endcase
                    len = 0;
                end
            end
            p_st = dbg_state; p_pc = dbg_pc; p_ir = dbg_ir; p_addr = mem_addr;
        end
    end

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", dbg_state, 3'd0);
            finish_up();
        end
    end

    initial begin
        foreach (mem[k]) mem[k] = 16'h0000;
        mem[0]  = e_ldr(1, 0, 20);     // R4: R1 = 5
        mem[1]  = e_ldr(2, 0, 21);     // R4: R2 = 0x1234
        mem[2]  = e_add(3, 1, 2);      // R3
        mem[3]  = e_ldr(4, 1, -1);     // R4: negative offset, loads word 4
        mem[4]  = e_add(5, 3, 3);      // R3
        mem[5]  = 16'hF025;            // R6: unsupported opcode
        mem[6]  = e_ldr(6, 0, 22);
        mem[7]  = e_ldr(0, 0, 23);     // R0 = 10
        mem[8]  = e_jmp(0);            // R5: jump over word 9
        mem[9]  = 16'hFFFF;
        mem[10] = e_add(7, 7, 5);      // R3: accumulates until it wraps
        mem[11] = e_ldr(1, 7, 0);      // exposes R7 on mem_addr
        mem[12] = e_jmp(0);            // R5: back to 10
        mem[20] = 16'h0005;
        mem[21] = 16'h1234;
        mem[22] = 16'h8001;
        mem[23] = 16'h000A;

        repeat (3) @(negedge clk);
        // R1 reset values
        check(dbg_state == 3'd0, "R1 phase", 16'(dbg_state), 16'd0);
        check(dbg_pc == 16'h0000, "R1 pc", dbg_pc, 16'h0000);
        check(dbg_ir == 16'h0000, "R1 ir", dbg_ir, 16'h0000);
        check(mem_addr == 16'h0000, "R1 addr", mem_addr, 16'h0000);
        rst_n = 1'b1;

        for (int c = 0; c < 420; c++) begin
            @(negedge clk);
            run = !((c >= 30 && c < 34) || (c >= 95 && c < 97) || c == 200);
        end
        run = 1'b1;
        @(negedge clk);
        done = 1;
        // R1 again: reset in the middle of a run returns to the start state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dbg_state == 3'd0 && dbg_pc == 16'h0000, "R1 rerun", dbg_pc, 16'h0000);
        finish_up();
    end
endmodule